// File: doc/BRIEF.md
# Serial EEPROM configuration loader

This block fetches a device's power-up configuration from a small three-wire serial EEPROM. When reset is released it walks the EEPROM word by word. It drives chip select, a divided serial clock and the command line, and it shifts each 16-bit word back in from the EEPROM data line. Every word is presented once on a word stream, so a wider register file can capture it. The first few words hold the station address. The block keeps those bytes in its own small RAM, which a host reads through a byte-wide I/O read port.

An 8-bit byte checksum runs over the low part of the EEPROM. The read then continues through a further region whose bits are meant for external shift registers, which clock from the same serial clock and data line. The busy output stays high for the whole read. It drops only at the very end, and only if the checksum was good, so the falling edge can latch those external registers. A bad checksum leaves busy high for good and raises the relocatable-mode flag. So does a board that fits no EEPROM, where the busy pin floats high during reset.

Top module: `eecfg_loader`

## Requirements
- R1: After reset is released, words 0 to SCAN_LAST (default 35) are read in ascending address order. Each read raises chip select, then sends the bits 1, 1, 0, then the 6-bit word address MSB first, each bit set up while the serial clock is low. It then takes 16 data bits MSB first, sampling the data line at the end of each clock-high phase. Chip select drops between words and stays low after the last word.
- R2: Each word read is presented exactly once, as a one-cycle pulse on cfg_wvalid with its address on cfg_waddr and the data read on cfg_wdata.
- R3: busy_o is high during reset and stays high until the read of the last word has completed. busy_o never rises after reset.
- R4: The checksum is the 8-bit sum, carries discarded, of both bytes of every word from 00h to CHK_LAST (default 1Bh). If it equals FFh, then after the last word busy_o goes low, cksum_ok and cfg_done go high, and reloc_mode stays low.
- R5: If that sum is not FFh, then after the last word cfg_done goes high, cksum_ok stays low, reloc_mode goes high and busy_o stays high.
- R6: Words above CHK_LAST are read and presented on the word stream but do not enter the checksum.
- R7: If busy_sense is high in the last cycle of reset, no EEPROM is fitted. Chip select never rises, no words are presented, and cfg_done and reloc_mode go high while busy_o stays high and cksum_ok stays low.
- R8: The address RAM holds MAC_BYTES (default 6) bytes loaded from words 0 to MAC_BYTES/2-1. Byte 2k is the low byte of word k and byte 2k+1 is its high byte. A host read (host_rd high, host_wr low) of host_addr returns that byte on host_rdata in the next cycle. The RAM and host_rdata are zero after reset.
- R9: A cycle with host_wr high changes neither host_rdata nor any RAM byte.
- R10: A host read issued in the same cycle as the RAM load of that byte returns the byte's previous contents. The new value appears on the following read.
- R11: During reset ee_cs, ee_sclk, ee_di, cfg_done, cksum_ok, reloc_mode and cfg_wvalid are low and host_rdata is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_sense | input | 1 | Busy pin level seen during reset; high means no EEPROM |
| ee_do | input | 1 | EEPROM serial data out |
| host_rd | input | 1 | Host I/O read strobe for the address window |
| host_wr | input | 1 | Host I/O write strobe; ignored |
| host_addr | input | HA_W (3) | Byte index within the address window |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sclk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | EEPROM serial data in (command and address) |
| busy_o | output | 1 | Busy strobe; falls only after a good read |
| cfg_done | output | 1 | Load sequence finished |
| cksum_ok | output | 1 | Checksum equalled FFh |
| reloc_mode | output | 1 | Fallback to software-relocatable mode |
| cfg_wvalid | output | 1 | One-cycle pulse per word read |
| cfg_waddr | output | 6 | Address of the presented word |
| cfg_wdata | output | 16 | Data of the presented word |
| host_rdata | output | 8 | Address byte returned for a host read |

## Verification
The two functions that can land in one cycle are a host read and the loader writing the same byte of the address RAM. The bench holds a read of byte 0 active through the whole load. It finds the cycle in which word 0 appears on the word stream and judges host_rdata on the two following cycles: it must show the old zero and then the low byte of word 0. A second overlap is a host write issued together with a read. It is judged by host_rdata keeping its previous value and by a later plain read returning the loaded byte unchanged.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;

    localparam int EE_AW      = 6;
    localparam int WORD_W     = 16;
    localparam int CMD_W      = 3 + EE_AW;
    localparam int FRAME_BITS = CMD_W + WORD_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEL,
        ST_LOW,
        ST_HIGH,
        ST_DESEL,
        ST_DONE
    } seq_st_t;

    typedef struct packed {
        logic              valid;
        logic [EE_AW-1:0]  addr;
        logic [WORD_W-1:0] data;
    } word_evt_t;

    function automatic logic [CMD_W-1:0] rd_cmd(input logic [EE_AW-1:0] a);
        return {3'b110, a};
    endfunction

    function automatic logic [7:0] byte_fold(input logic [7:0] acc,
                                             input logic [WORD_W-1:0] w);
        logic [7:0] s;
        s = acc + w[7:0];
        s = s + w[15:8];
        return s;
    endfunction

endpackage

// File: rtl/eecfg_bitclk.sv
module eecfg_bitclk #(
    parameter int CLK_HALF = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic tick
);
    localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(CLK_HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = en && (cnt == LAST);
endmodule

// File: rtl/eecfg_seq.sv
module eecfg_seq
    import eecfg_pkg::*;
#(
    parameter int SCAN_LAST = 35
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      skip,
    input  logic      ee_do,
    output logic      run,
    output logic      ee_cs,
    output logic      ee_sclk,
    output logic      ee_di,
    output logic      fin,
    output word_evt_t evt
);
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [EE_AW-1:0] LAST_W     = EE_AW'(SCAN_LAST);
    localparam logic [BIT_W-1:0] BIT_END    = BIT_W'(FRAME_BITS - 1);
    localparam logic [BIT_W-1:0] DATA_FIRST = BIT_W'(CMD_W);

    seq_st_t           st;
    logic [EE_AW-1:0]  word;
    logic [BIT_W-1:0]  bitn;
    logic [CMD_W-1:0]  cmd_sh;
    logic [WORD_W-1:0] data_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            word    <= '0;
            bitn    <= '0;
            cmd_sh  <= '0;
            data_sh <= '0;
            evt     <= '0;
        end else begin
            evt.valid <= 1'b0;
            case (st)
                ST_IDLE: st <= skip ? ST_DONE : ST_SEL;
                ST_SEL: if (tick) begin
                    st     <= ST_LOW;
                    bitn   <= '0;
                    cmd_sh <= rd_cmd(word);
                end
                ST_LOW: if (tick) st <= ST_HIGH;
                ST_HIGH: if (tick) begin
                    cmd_sh <= {cmd_sh[CMD_W-2:0], 1'b0};
                    if (bitn >= DATA_FIRST)
                        data_sh <= {data_sh[WORD_W-2:0], ee_do};
                    if (bitn == BIT_END) begin
                        st         <= ST_DESEL;
                        evt.valid  <= 1'b1;
                        evt.addr   <= word;
                        evt.data   <= {data_sh[WORD_W-2:0], ee_do};
                    end else begin
                        bitn <= bitn + 1'b1;
                        st   <= ST_LOW;
                    end
                end
                ST_DESEL: if (tick) begin
                    if (word == LAST_W) begin
                        st <= ST_DONE;
                    end else begin
                        word <= word + 1'b1;
                        st   <= ST_SEL;
                    end
                end
                ST_DONE: st <= ST_DONE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        run     = (st == ST_SEL) || (st == ST_LOW) || (st == ST_HIGH) || (st == ST_DESEL);
        ee_cs   = (st == ST_SEL) || (st == ST_LOW) || (st == ST_HIGH);
        ee_sclk = (st == ST_HIGH);
        ee_di   = ((st == ST_LOW) || (st == ST_HIGH)) && cmd_sh[CMD_W-1];
        fin     = (st == ST_DONE);
    end

    // R1
    sclk_in_frame_chk: assert property (@(posedge clk) disable iff (rst)
        ee_sclk |-> ee_cs);

    // R2
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        evt.valid |=> !evt.valid);

    // R1
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        fin |=> (fin && !ee_cs));
endmodule

// File: rtl/eecfg_cksum.sv
module eecfg_cksum
    import eecfg_pkg::*;
#(
    parameter int CHK_LAST = 27
) (
    input  logic      clk,
    input  logic      rst,
    input  word_evt_t evt,
    output logic      pass
);
    localparam logic [EE_AW-1:0] CHK_W = EE_AW'(CHK_LAST);

    logic [7:0] acc;
    logic       covered;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc     <= '0;
            covered <= 1'b0;
        end else if (evt.valid && (evt.addr <= CHK_W)) begin
            acc <= byte_fold(acc, evt.data);
            if (evt.addr == CHK_W) covered <= 1'b1;
        end
    end

    assign pass = covered && (acc == 8'hFF);

    // R6
    scan_words_skip_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && (evt.addr > CHK_W)) |=> $stable(acc));
endmodule

// File: rtl/eecfg_addr_ram.sv
module eecfg_addr_ram
    import eecfg_pkg::*;
#(
    parameter int MAC_BYTES = 6,
    localparam int HA_W = (MAC_BYTES > 1) ? $clog2(MAC_BYTES) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  word_evt_t       evt,
    input  logic            host_rd,
    input  logic            host_wr,
    input  logic [HA_W-1:0] host_addr,
    output logic [7:0]      host_rdata
);
    logic [7:0] rd_vec [MAC_BYTES];

    for (genvar i = 0; i < MAC_BYTES; i++) begin : g_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (evt.valid && (evt.addr == EE_AW'(i / 2))) begin
                byte_q <= (i % 2 == 1) ? evt.data[15:8] : evt.data[7:0];
            end
        end
        assign rd_vec[i] = byte_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_rdata <= '0;
        end else if (host_rd && !host_wr) begin
            host_rdata <= (32'(host_addr) < MAC_BYTES) ? rd_vec[host_addr] : 8'h00;
        end
    end

    // R9
    wr_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        host_wr |=> $stable(host_rdata));
endmodule

// File: rtl/eecfg_loader.sv
module eecfg_loader
    import eecfg_pkg::*;
#(
    parameter int CHK_LAST  = 27,
    parameter int SCAN_LAST = 35,
    parameter int MAC_BYTES = 6,
    parameter int CLK_HALF  = 2,
    localparam int HA_W = (MAC_BYTES > 1) ? $clog2(MAC_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy_sense,
    input  logic              ee_do,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [HA_W-1:0]   host_addr,
    output logic              ee_cs,
    output logic              ee_sclk,
    output logic              ee_di,
    output logic              busy_o,
    output logic              cfg_done,
    output logic              cksum_ok,
    output logic              reloc_mode,
    output logic              cfg_wvalid,
    output logic [EE_AW-1:0]  cfg_waddr,
    output logic [WORD_W-1:0] cfg_wdata,
    output logic [7:0]        host_rdata
);
    logic      run, tick, fin, pass, no_ee_q, good;
    word_evt_t evt;

    eecfg_bitclk #(.CLK_HALF(CLK_HALF)) u_bitclk (
        .clk(clk), .rst(rst), .en(run), .tick(tick)
    );

    eecfg_seq #(.SCAN_LAST(SCAN_LAST)) u_seq (
        .clk(clk), .rst(rst), .tick(tick), .skip(no_ee_q), .ee_do(ee_do),
        .run(run), .ee_cs(ee_cs), .ee_sclk(ee_sclk), .ee_di(ee_di),
        .fin(fin), .evt(evt)
    );

    eecfg_cksum #(.CHK_LAST(CHK_LAST)) u_cksum (
        .clk(clk), .rst(rst), .evt(evt), .pass(pass)
    );

    eecfg_addr_ram #(.MAC_BYTES(MAC_BYTES)) u_ram (
        .clk(clk), .rst(rst), .evt(evt), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_rdata(host_rdata)
    );

    assign good = fin && pass && !no_ee_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            no_ee_q    <= busy_sense;
            busy_o     <= 1'b1;
            cfg_done   <= 1'b0;
            cksum_ok   <= 1'b0;
            reloc_mode <= 1'b0;
        end else begin
            cfg_done   <= fin;
            cksum_ok   <= good;
            reloc_mode <= fin && !good;
            busy_o     <= !good;
        end
    end

    assign cfg_wvalid = evt.valid;
    assign cfg_waddr  = evt.addr;
    assign cfg_wdata  = evt.data;

    // R3
    busy_never_rises_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(busy_o));

    // R4
    ok_releases_busy_chk: assert property (@(posedge clk) disable iff (rst)
        cksum_ok |-> (!busy_o && cfg_done && !reloc_mode));

    // R5
    reloc_keeps_busy_chk: assert property (@(posedge clk) disable iff (rst)
        reloc_mode |-> (busy_o && cfg_done && !cksum_ok));

    // R7
    absent_no_select_chk: assert property (@(posedge clk) disable iff (rst)
        no_ee_q |-> (!ee_cs && !cfg_wvalid));
endmodule

// File: tb/eecfg_loader_tb.sv
`timescale 1ns/1ps
module eecfg_loader_tb;
    localparam int NWORDS = 36;
    localparam int CHKW   = 28;
    localparam int NVEC   = 4;
    // fields: seed[7:0], make_good, no_eeprom, expected cksum_ok
    localparam logic [10:0] VEC [NVEC] = '{
        {8'h11, 1'b1, 1'b0, 1'b1},
        {8'h5A, 1'b0, 1'b0, 1'b0},
        {8'hC3, 1'b1, 1'b0, 1'b1},
        {8'h00, 1'b1, 1'b1, 1'b0}
    };

    logic clk = 0, rst = 1, busy_sense = 0, ee_do = 0;
    logic host_rd = 0, host_wr = 0;
    logic [2:0] host_addr = 0;
    logic ee_cs, ee_sclk, ee_di, busy_o, cfg_done, cksum_ok, reloc_mode, cfg_wvalid;
    logic [5:0]  cfg_waddr;
    logic [15:0] cfg_wdata;
    logic [7:0]  host_rdata;

    eecfg_loader u_dut (
        .clk(clk), .rst(rst), .busy_sense(busy_sense), .ee_do(ee_do),
        .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
        .ee_cs(ee_cs), .ee_sclk(ee_sclk), .ee_di(ee_di), .busy_o(busy_o),
        .cfg_done(cfg_done), .cksum_ok(cksum_ok), .reloc_mode(reloc_mode),
        .cfg_wvalid(cfg_wvalid), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
        .host_rdata(host_rdata)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int cs_rises = 0, cmd_err = 0, bitc = 0, exp_w = 0, busy_err = 0;
    logic [15:0] mem [64];
    logic [5:0]  a_sh;

    task automatic chk(input logic ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // EEPROM model
    always @(posedge ee_cs) begin
        bitc = 0;
        cs_rises++;
    end
    always @(posedge ee_sclk) begin
        bitc++;
        if (bitc <= 3) begin
            if (ee_di != (bitc != 3)) cmd_err++;
        end else if (bitc <= 9) begin
            a_sh = {a_sh[4:0], ee_di};
        end
    end
    always @(negedge ee_sclk) begin
        int c;
        c = bitc;
        if (c >= 9 && c < 25) begin
            #1 ee_do = mem[a_sh][15 - (c - 9)];
        end
    end

    // word stream monitor (R1, R2, R6)
    always @(negedge clk) begin
        if (!rst && cfg_wvalid) begin
            chk(cfg_waddr == 6'(exp_w), "R1 word order", 32'(cfg_waddr), 32'(exp_w));
            chk(cfg_wdata == mem[cfg_waddr], "R2 word data", 32'(cfg_wdata), 32'(mem[cfg_waddr]));
            exp_w++;
        end
        if (!rst && !cfg_done && !busy_o) busy_err++;
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected below 190000", cyc);
            finish_run();
        end
    end

    task automatic fill(input logic [7:0] seed, input logic good);
        logic [7:0] s;
        for (int w = 0; w < 64; w++)
            mem[w] = {8'(seed ^ 8'(w * 3)), 8'(seed + 8'(w * 7) + 8'h1)};
        s = 0;
        for (int w = 0; w < CHKW - 1; w++) s = s + mem[w][7:0] + mem[w][15:8];
        s = s + mem[CHKW-1][15:8];
        mem[CHKW-1][7:0] = good ? (8'hFF - s) : (8'hFE - s);
    endtask

    function automatic logic [7:0] sum_range(input int last);
        logic [7:0] s;
        s = 0;
        for (int w = 0; w <= last; w++) s = s + mem[w][7:0] + mem[w][15:8];
        return s;
    endfunction

    initial begin
        for (int v = 0; v < NVEC; v++) begin
            logic [7:0] seed;
            logic mk_good, no_ee, exp_ok, calc_ok;
            logic [7:0] exp_b;
            int t;
            {seed, mk_good, no_ee, exp_ok} = VEC[v];
            fill(seed, mk_good);
            calc_ok = !no_ee && (sum_range(CHKW - 1) == 8'hFF);
            chk(calc_ok == exp_ok, "R4 table sanity", 32'(calc_ok), 32'(exp_ok));
            if (v == 2)
                // R6: the sum over every word read is not FFh here
                chk(sum_range(NWORDS - 1) != 8'hFF, "R6 scan bytes excluded",
                    32'(sum_range(NWORDS - 1)), 32'hFF);
            rst = 1;
            busy_sense = no_ee;
            host_rd = (v == 0);
            host_addr = 0;
            host_wr = 0;
            repeat (3) @(negedge clk);
            // R11 reset state
            chk({ee_cs, ee_sclk, ee_di, cfg_done, cksum_ok, reloc_mode, cfg_wvalid} == 7'b0,
                "R11 reset outputs", 32'({ee_cs, ee_sclk, ee_di, cfg_done, cksum_ok, reloc_mode, cfg_wvalid}), 0);
            chk(busy_o == 1'b1, "R3 busy in reset", 32'(busy_o), 1);
            chk(host_rdata == 8'h00, "R11 rdata reset", 32'(host_rdata), 0);
            cs_rises = 0; cmd_err = 0; exp_w = 0; busy_err = 0;
            rst = 0;
            busy_sense = 0;
            if (v == 0) begin
                // R10: read of byte 0 overlaps its load
                t = 0;
                while (!(cfg_wvalid && cfg_waddr == 6'd0) && t < 20000) begin
                    @(negedge clk);
                    t++;
                end
                @(negedge clk);
                chk(host_rdata == 8'h00, "R10 old byte on overlap", 32'(host_rdata), 0);
                @(negedge clk);
                chk(host_rdata == mem[0][7:0], "R10 new byte after", 32'(host_rdata), 32'(mem[0][7:0]));
                host_rd = 0;
            end
            t = 0;
            while (!cfg_done && t < 20000) begin
                @(negedge clk);
                t++;
            end
            chk(cfg_done == 1'b1, "R5 cfg_done", 32'(cfg_done), 1);
            repeat (3) @(negedge clk);
            chk(cksum_ok == exp_ok, "R4 cksum_ok", 32'(cksum_ok), 32'(exp_ok));
            chk(busy_o == !exp_ok, "R5 busy after load", 32'(busy_o), 32'(!exp_ok));
            chk(reloc_mode == !exp_ok, "R5 reloc_mode", 32'(reloc_mode), 32'(!exp_ok));
            chk(busy_err == 0, "R3 busy low early", busy_err, 0);
            chk(cmd_err == 0, "R1 command bits", cmd_err, 0);
            chk(ee_cs == 1'b0, "R1 cs low at end", 32'(ee_cs), 0);
            if (no_ee) begin
                chk(cs_rises == 0, "R7 no select", cs_rises, 0);
                chk(exp_w == 0, "R7 no words", exp_w, 0);
            end else begin
                chk(cs_rises == NWORDS, "R1 select count", cs_rises, NWORDS);
                chk(exp_w == NWORDS, "R1 word count", exp_w, NWORDS);
            end
            // R8 address RAM contents
            for (int b = 0; b < 6; b++) begin
                host_addr = 3'(b);
                host_rd = 1;
                @(negedge clk);
                host_rd = 0;
                exp_b = no_ee ? 8'h00 : ((b % 2 == 1) ? mem[b/2][15:8] : mem[b/2][7:0]);
                chk(host_rdata == exp_b, "R8 address byte", 32'(host_rdata), 32'(exp_b));
            end
            if (v == 1) begin
                // R9: write strobe ignored
                host_addr = 0; host_rd = 1;
                @(negedge clk);
                host_addr = 1; host_wr = 1;
                @(negedge clk);
                chk(host_rdata == mem[0][7:0], "R9 rdata held on write", 32'(host_rdata), 32'(mem[0][7:0]));
                host_wr = 0;
                @(negedge clk);
                host_rd = 0;
                chk(host_rdata == mem[0][15:8], "R9 byte unchanged", 32'(host_rdata), 32'(mem[0][15:8]));
            end
        end
        finish_run();
    end
endmodule